// File: doc/BRIEF.md
# Storage Bus DMA Channel

This block is the single bus-master channel that sits between the byte FIFO of a storage bus core and a word-wide memory port. Software sets up a transfer through a small register window. It writes a start count and a start address, then writes a command byte that carries a two-bit operation and a direction bit. The channel then moves bytes between the FIFO and memory one 32-bit word request at a time. Byte enables cover a start address that is not aligned and a final word that is only partly filled.

Before a transfer starts, its length is clamped. The limit is 2^16 bytes, or 2^24 bytes when the extended-count input is high. The length is then cut again so that the transfer stops exactly at the next 2^24-byte address boundary. Completion, a memory error, an abort and the bus core's own interrupt are collected into a status byte, and any of them raises the interrupt output. A flush operation writes whatever bytes the FIFO still presents to memory at the working address and then reports that the flush is finished.

Top module: `storage_dma_chan`

## Requirements
- R1: After reset the status byte reads 0x00, `irq_pend` is low and `mem_req` is low.
- R2: The register window is decoded from `reg_addr[7:2]`: 0x40 command, 0x44 start count, 0x48 start address, 0x4C working count, 0x50 working address, 0x54 status. The command field is bits [1:0] (0 idle, 1 flush, 2 abort, 3 start). Writing start loads the working count and address from the start registers and begins a transfer.
- R3: Command bit 7 set means memory is written with bytes from the FIFO source. A beat's bytes go to ascending byte lanes, and a request holds its address and byte enables until `mem_ack`.
- R4: With command bit 7 clear, memory is read, and the bytes are handed to the sink in ascending address order.
- R5: Each beat starts at lane `addr[1:0]` and covers the smaller of the bytes left in that word and the bytes remaining. Its `mem_be` has exactly those lanes set, and `mem_addr` is word aligned.
- R6: The working count loaded by start is min(start count, 2^16), or min(start count, 2^24) when `ext_count_en` is high.
- R7: The loaded length is further reduced so that start address bits [23:0] plus the length never exceed 2^24.
- R8: When the count runs out, status bit 3 (done) sets and `irq_pend` rises.
- R9: A memory response with `mem_err` sets status bit 1 and the channel issues no further requests. Writing abort sets status bit 2 and stops the channel. Writing idle clears status bits 1, 2, 3 and 5.
- R10: Status bit 4 follows `core_int` directly, and `core_int` alone raises `irq_pend`.
- R11: Flush, issued while the channel is idle with bit 7 set, writes every byte the source still presents to memory, starting at the working address, and does not change the working count. When the source runs dry it sets status bit 5, and that bit does not raise `irq_pend`.
- R12: The working count drops and the working address rises by each completed beat's byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ext_count_en | input | 1 | Selects the 2^24 length limit instead of 2^16 |
| core_int | input | 1 | Interrupt forwarded from the bus core |
| irq_pend | output | 1 | Interrupt pending |
| src_valid | input | 1 | FIFO byte available toward memory |
| src_data | input | 8 | FIFO byte toward memory |
| src_ready | output | 1 | Channel takes the source byte |
| snk_valid | output | 1 | Byte from memory available to the FIFO |
| snk_data | output | 8 | Byte from memory |
| snk_ready | input | 1 | FIFO takes the sink byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Request failed, valid with `mem_ack` |

## Verification
One write transfer starts word aligned and ends on a two-byte tail. A read transfer starts at lane 3 and ends at lane 0, so both partial-word masks and the lane-to-byte order are exercised in each direction. A write placed seven bytes below the 2^24 line separates the boundary cut from the length cap. Two oversized counts, one with the extended limit and one without, separate the 16-bit cap from the 24-bit cap. An injected memory error, an abort, the forwarded core interrupt and a three-byte flush each show which status bit sets, whether it reaches the interrupt, and that idle clears it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WR,
    ST_RD,
    ST_DRAIN,
    ST_HALT
  } xfer_st_e;

  localparam int unsigned DIR_BIT = 7;

  // word offsets of the register window (byte address = offset * 4)
  localparam logic [5:0] OFS_CMD  = 6'h10;
  localparam logic [5:0] OFS_CNT  = 6'h11;
  localparam logic [5:0] OFS_ADR  = 6'h12;
  localparam logic [5:0] OFS_WCNT = 6'h13;
  localparam logic [5:0] OFS_WADR = 6'h14;
  localparam logic [5:0] OFS_STAT = 6'h15;

  // bytes a beat may carry: up to the word end, never past the remainder
  function automatic logic [2:0] lane_span(input logic [1:0] lo, input logic [31:0] rem);
    logic [2:0] room;
    room = 3'd4 - {1'b0, lo};
    if (rem < 32'(room)) lane_span = rem[2:0];
    else                 lane_span = room;
  endfunction

  // byte-enable mask for n bytes starting at lane lo
  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [2:0] n);
    logic [3:0] m;
    m = 4'b0000;
    for (int i = 0; i < 4; i++) begin
      if (i >= int'(lo) && i < int'(lo) + int'(n)) m[i] = 1'b1;
    end
    lane_mask = m;
  endfunction

endpackage

// File: rtl/dmac_clamp.sv
module dmac_clamp #(
  parameter int unsigned SHORT_LOG2 = 16,
  parameter int unsigned LONG_LOG2  = 24,
  parameter int unsigned BOUND_LOG2 = 24,
  localparam int unsigned CW = LONG_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   req_cnt,
  input  logic [31:0]   base_adr,
  input  logic          ext_en,
  output logic [CW-1:0] len
);

  localparam logic [32:0] SHORT_LIM = 33'd1 << SHORT_LOG2;
  localparam logic [32:0] LONG_LIM  = 33'd1 << LONG_LOG2;
  localparam logic [32:0] BOUND     = 33'd1 << BOUND_LOG2;

  function automatic logic [32:0] fit_len(input logic [31:0] cnt, input logic [31:0] adr,
                                          input logic ext);
    logic [32:0] lim, cap, room;
    lim  = ext ? LONG_LIM : SHORT_LIM;
    cap  = ({1'b0, cnt} > lim) ? lim : {1'b0, cnt};
    room = BOUND - 33'(adr[BOUND_LOG2-1:0]);
    fit_len = (cap > room) ? room : cap;
  endfunction

  logic [32:0] full_len;
  assign full_len = fit_len(req_cnt, base_adr, ext_en);
  assign len      = full_len[CW-1:0];

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (33'(len) <= (ext_en ? LONG_LIM : SHORT_LIM)) && (33'(len) <= {1'b0, req_cnt}));

  // R7
  bound_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (33'(len) + 33'(base_adr[BOUND_LOG2-1:0])) <= BOUND);

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [31:0]   req_cnt,
  output logic [31:0]   req_adr,
  output logic          op_start,
  output logic          op_abort,
  output logic          op_flush,
  output logic          op_idle,
  output logic          op_dir,
  input  logic          ev_done,
  input  logic          ev_err,
  input  logic          ev_flush,
  input  logic          core_int,
  input  logic [CW-1:0] wcnt,
  input  logic [31:0]   wadr,
  output logic          irq_pend
);

  logic [7:0] cmd_q;
  logic       err_f, abt_f, done_f, fl_f;
  logic [7:0] stat;
  logic       hit_cmd;
  dma_op_e    op;

  assign hit_cmd  = wr_en && (addr[7:2] == OFS_CMD);
  assign op       = dma_op_e'(wdata[1:0]);
  assign op_start = hit_cmd && (op == OP_START);
  assign op_abort = hit_cmd && (op == OP_ABORT);
  assign op_flush = hit_cmd && (op == OP_FLUSH);
  assign op_idle  = hit_cmd && (op == OP_IDLE);
  assign op_dir   = wdata[DIR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      req_cnt <= 32'h0;
      req_adr <= 32'h0;
    end else if (wr_en) begin
      case (addr[7:2])
        OFS_CMD: cmd_q   <= wdata[7:0];
        OFS_CNT: req_cnt <= wdata;
        OFS_ADR: req_adr <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_f  <= 1'b0;
      abt_f  <= 1'b0;
      done_f <= 1'b0;
      fl_f   <= 1'b0;
    end else if (op_idle) begin
      err_f  <= 1'b0;
      abt_f  <= 1'b0;
      done_f <= 1'b0;
      fl_f   <= 1'b0;
    end else begin
      if (ev_err)   err_f  <= 1'b1;
      if (op_abort) abt_f  <= 1'b1;
      if (ev_done)  done_f <= 1'b1;
      if (ev_flush) fl_f   <= 1'b1;
    end
  end

  // bit 0 reports power-down, which this channel never enters
  assign stat     = {2'b00, fl_f, core_int, done_f, abt_f, err_f, 1'b0};
  assign irq_pend = err_f | abt_f | done_f | core_int;

  always_comb begin
    case (addr[7:2])
      OFS_CMD:  rdata = {24'h0, cmd_q};
      OFS_CNT:  rdata = req_cnt;
      OFS_ADR:  rdata = req_adr;
      OFS_WCNT: rdata = 32'(wcnt);
      OFS_WADR: rdata = wadr;
      OFS_STAT: rdata = {24'h0, stat};
      default:  rdata = 32'h0;
    endcase
  end

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !op_idle) |=> irq_pend);

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_idle |=> (stat[1] == 1'b0) && (stat[2] == 1'b0) && (stat[3] == 1'b0) && (stat[5] == 1'b0));

  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flush && !irq_pend && !ev_err && !ev_done && !op_abort) |=> (irq_pend == core_int));

endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
#(
  parameter int unsigned CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          halt_req,
  input  logic          flush,
  input  logic          dir_wr,
  input  logic [CW-1:0] ld_len,
  input  logic [31:0]   ld_adr,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_ready,
  output logic          snk_valid,
  output logic [7:0]    snk_data,
  input  logic          snk_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          ev_done,
  output logic          ev_err,
  output logic          ev_flush,
  output logic [CW-1:0] wcnt,
  output logic [31:0]   wadr
);

  xfer_st_e    st, st_n;
  logic [CW-1:0] wcnt_n;
  logic [31:0] wadr_n;
  logic [2:0]  got, got_n;
  logic [31:0] lanes, lanes_n;
  logic        fl_m, fl_m_n;

  logic [1:0]  lo;
  logic [2:0]  need;
  logic [1:0]  lane;
  logic [2:0]  beat_n;
  logic        last_beat;

  assign lo        = wadr[1:0];
  assign need      = fl_m ? (3'd4 - {1'b0, lo}) : lane_span(lo, 32'(wcnt));
  assign lane      = lo + got[1:0];
  assign beat_n    = (st == ST_WR) ? got : need;
  assign last_beat = (wcnt == CW'(need));

  assign src_ready = (st == ST_FILL);
  assign snk_valid = (st == ST_DRAIN);
  assign snk_data  = lanes[{lane, 3'b000} +: 8];
  assign mem_req   = (st == ST_WR) || (st == ST_RD);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = {wadr[31:2], 2'b00};
  assign mem_be    = lane_mask(lo, beat_n);
  assign mem_wdata = lanes;

  always_comb begin
    st_n     = st;
    wcnt_n   = wcnt;
    wadr_n   = wadr;
    got_n    = got;
    lanes_n  = lanes;
    fl_m_n   = fl_m;
    ev_done  = 1'b0;
    ev_err   = 1'b0;
    ev_flush = 1'b0;
    if (halt_req) begin
      st_n   = ST_IDLE;
      got_n  = 3'd0;
      fl_m_n = 1'b0;
    end else if (go) begin
      wcnt_n = ld_len;
      wadr_n = ld_adr;
      got_n  = 3'd0;
      fl_m_n = 1'b0;
      if (ld_len == '0) begin
        st_n    = ST_IDLE;
        ev_done = 1'b1;
      end else begin
        st_n = dir_wr ? ST_FILL : ST_RD;
      end
    end else if (flush) begin
      if (st == ST_IDLE) begin
        if (dir_wr) begin
          st_n   = ST_FILL;
          fl_m_n = 1'b1;
          got_n  = 3'd0;
        end else begin
          ev_flush = 1'b1;
        end
      end
    end else begin
      case (st)
        ST_FILL: begin
          if (src_valid) begin
            lanes_n[{lane, 3'b000} +: 8] = src_data;
            got_n = got + 3'd1;
            if (got + 3'd1 == need) st_n = ST_WR;
          end else if (fl_m) begin
            if (got == 3'd0) begin
              st_n     = ST_IDLE;
              fl_m_n   = 1'b0;
              ev_flush = 1'b1;
            end else begin
              st_n = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_ack) begin
            if (mem_err) begin
              st_n   = ST_HALT;
              ev_err = 1'b1;
            end else begin
              wadr_n = wadr + 32'(got);
              got_n  = 3'd0;
              if (fl_m) begin
                st_n = ST_FILL;
              end else begin
                wcnt_n = wcnt - CW'(got);
                if (wcnt == CW'(got)) begin
                  st_n    = ST_IDLE;
                  ev_done = 1'b1;
                end else begin
                  st_n = ST_FILL;
                end
              end
            end
          end
        end
        ST_RD: begin
          if (mem_ack) begin
            if (mem_err) begin
              st_n   = ST_HALT;
              ev_err = 1'b1;
            end else begin
              lanes_n = mem_rdata;
              got_n   = 3'd0;
              st_n    = ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (snk_ready) begin
            got_n = got + 3'd1;
            if (got + 3'd1 == need) begin
              wadr_n = wadr + 32'(need);
              wcnt_n = wcnt - CW'(need);
              got_n  = 3'd0;
              if (last_beat) begin
                st_n    = ST_IDLE;
                ev_done = 1'b1;
              end else begin
                st_n = ST_RD;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      wcnt  <= '0;
      wadr  <= 32'h0;
      got   <= 3'd0;
      lanes <= 32'h0;
      fl_m  <= 1'b0;
    end else begin
      st    <= st_n;
      wcnt  <= wcnt_n;
      wadr  <= wadr_n;
      got   <= got_n;
      lanes <= lanes_n;
      fl_m  <= fl_m_n;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !halt_req && !go) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 4'b0000));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !go) |=> !mem_req);

  // R12
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !mem_err && !fl_m && !halt_req && !go && !flush) |=>
      (wcnt < $past(wcnt)) && (wadr > $past(wadr)));

endmodule

// File: rtl/storage_dma_chan.sv
module storage_dma_chan
  import dmac_pkg::*;
#(
  parameter int unsigned SHORT_LOG2 = 16,
  parameter int unsigned LONG_LOG2  = 24,
  parameter int unsigned BOUND_LOG2 = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_count_en,
  input  logic        core_int,
  output logic        irq_pend,
  input  logic        src_valid,
  input  logic [7:0]  src_data,
  output logic        src_ready,
  output logic        snk_valid,
  output logic [7:0]  snk_data,
  input  logic        snk_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);

  localparam int unsigned CW = LONG_LOG2 + 1;

  logic [31:0]   req_cnt, req_adr;
  logic          op_start, op_abort, op_flush, op_idle, op_dir;
  logic          ev_done, ev_err, ev_flush;
  logic [CW-1:0] wcnt, fit;
  logic [31:0]   wadr;

  dmac_regs #(.CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .req_cnt  (req_cnt),
    .req_adr  (req_adr),
    .op_start (op_start),
    .op_abort (op_abort),
    .op_flush (op_flush),
    .op_idle  (op_idle),
    .op_dir   (op_dir),
    .ev_done  (ev_done),
    .ev_err   (ev_err),
    .ev_flush (ev_flush),
    .core_int (core_int),
    .wcnt     (wcnt),
    .wadr     (wadr),
    .irq_pend (irq_pend)
  );

  dmac_clamp #(
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2),
    .BOUND_LOG2 (BOUND_LOG2)
  ) u_clamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_cnt  (req_cnt),
    .base_adr (req_adr),
    .ext_en   (ext_count_en),
    .len      (fit)
  );

  dmac_xfer #(.CW(CW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (op_start),
    .halt_req  (op_abort | op_idle),
    .flush     (op_flush),
    .dir_wr    (op_dir),
    .ld_len    (fit),
    .ld_adr    (req_adr),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .snk_valid (snk_valid),
    .snk_data  (snk_data),
    .snk_ready (snk_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .ev_done   (ev_done),
    .ev_err    (ev_err),
    .ev_flush  (ev_flush),
    .wcnt      (wcnt),
    .wadr      (wadr)
  );

  // R10
  core_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_int |-> irq_pend);

endmodule

// File: tb/tb_storage_dma_chan.sv
module tb_storage_dma_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        ext_count_en = 1'b0;
  logic        core_int = 1'b0;
  logic        irq_pend;
  logic        src_valid = 1'b0;
  logic [7:0]  src_data = 8'h0;
  logic        src_ready;
  logic        snk_valid;
  logic [7:0]  snk_data;
  logic        snk_ready = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        mem_err = 1'b0;

  storage_dma_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_count_en(ext_count_en),
    .core_int(core_int), .irq_pend(irq_pend), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .snk_valid(snk_valid),
    .snk_data(snk_data), .snk_ready(snk_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err)
  );

  always #10 clk = ~clk;

  localparam logic [7:0] A_CMD = 8'h40, A_CNT = 8'h44, A_ADR = 8'h48,
                         A_WCNT = 8'h4C, A_WADR = 8'h50, A_STAT = 8'h54;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit src_hs = 1'b0;
  bit err_arm = 1'b0;

  logic [7:0]  src_q[$];
  logic [7:0]  snk_exp[$];
  logic [31:0] ex_addr[$];
  logic [3:0]  ex_be[$];
  logic        ex_we[$];
  logic [31:0] ex_data[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // reference beats: split [a, a+len) into word requests
  task automatic plan_beats(input logic [31:0] a, input int len, input bit we, input logic [7:0] first);
    logic [31:0] cur;
    int rem;
    int k;
    cur = a; rem = len; k = 0;
    while (rem > 0) begin
      int lo;
      int n;
      logic [3:0]  be;
      logic [31:0] d;
      lo = int'(cur[1:0]);
      n = (4 - lo < rem) ? 4 - lo : rem;
      be = 4'b0; d = 32'h0;
      for (int i = 0; i < n; i++) begin
        be[lo + i] = 1'b1;
        d[(lo + i) * 8 +: 8] = first + 8'(k);
        if (we) src_q.push_back(first + 8'(k));
        else snk_exp.push_back(mem_byte(cur + 32'(i)));
        k++;
      end
      ex_addr.push_back({cur[31:2], 2'b00});
      ex_be.push_back(be);
      ex_we.push_back(we);
      ex_data.push_back(d);
      cur = cur + 32'(n);
      rem = rem - n;
    end
  endtask

  // cycle-by-cycle stream and memory model
  always @(negedge clk) begin
    if (src_hs) void'(src_q.pop_front());
    src_valid = (src_q.size() > 0);
    src_data  = src_valid ? src_q[0] : 8'h00;
    src_hs    = src_valid && src_ready;
    snk_ready = ~snk_ready;
    if (rst_n && snk_valid && snk_ready) begin
      if (snk_exp.size() == 0) chk({24'h0, snk_data}, 32'hFFFF_FFFF, "R4 unexpected sink byte");
      else chk({24'h0, snk_data}, {24'h0, snk_exp.pop_front()}, "R4 sink byte order");
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (rst_n && mem_req) begin
      if (ex_addr.size() == 0) begin
        chk(mem_addr, 32'hFFFF_FFFF, "R3 unexpected request");
      end else begin
        logic [31:0] m;
        logic [3:0] eb;
        logic [31:0] ed;
        eb = ex_be[0];
        ed = ex_data[0];
        m = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
        chk(mem_addr, ex_addr.pop_front(), "R5 beat address");
        chk({28'h0, mem_be}, {28'h0, eb}, "R5 beat byte enables");
        chk({31'h0, mem_we}, {31'h0, ex_we.pop_front()}, "R3 beat direction");
        if (mem_we) chk(mem_wdata & m, ed & m, "R3 beat lane data");
        void'(ex_be.pop_front());
        void'(ex_data.pop_front());
      end
      mem_rdata = {mem_byte(mem_addr + 3), mem_byte(mem_addr + 2),
                   mem_byte(mem_addr + 1), mem_byte(mem_addr)};
      mem_err = err_arm;
      err_arm = 1'b0;
      mem_ack = 1'b1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic launch(input bit to_mem, input logic [31:0] cnt, input logic [31:0] adr);
    wr(A_CMD, {24'h0, to_mem, 7'h00});
    wr(A_CNT, cnt);
    wr(A_ADR, adr);
    wr(A_CMD, {24'h0, to_mem, 7'h03});
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      #1;
      if (irq_pend) break;
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(2);

    // R1 reset state
    rd(A_STAT, v); chk(v, 32'h00, "R1 status after reset");
    chk({31'h0, irq_pend}, 32'h0, "R1 irq after reset");
    chk({31'h0, mem_req}, 32'h0, "R1 no request after reset");

    // R2 R3 R5 R8 R12: write 10 bytes from 0x100
    plan_beats(32'h100, 10, 1'b1, 8'h10);
    launch(1'b1, 32'd10, 32'h100);
    wait_irq(200);
    rd(A_STAT, v); chk(v, 32'h08, "R8 done status");
    chk({31'h0, irq_pend}, 32'h1, "R8 irq on done");
    rd(A_WCNT, v); chk(v, 32'h0, "R12 working count drained");
    rd(A_WADR, v); chk(v, 32'h10A, "R12 working address advanced");
    rd(A_CMD, v); chk(v, 32'h83, "R2 command readback");
    chk(ex_addr.size(), 0, "R3 all write beats issued");

    // R9 idle clears
    wr(A_CMD, 32'h00);
    rd(A_STAT, v); chk(v, 32'h00, "R9 idle clears status");
    chk({31'h0, irq_pend}, 32'h0, "R9 irq low after idle");

    // R4 R5: read 6 bytes from 0x203
    plan_beats(32'h203, 6, 1'b0, 8'h00);
    launch(1'b0, 32'd6, 32'h203);
    wait_irq(200);
    rd(A_STAT, v); chk(v, 32'h08, "R4 read done");
    chk(snk_exp.size(), 0, "R4 all sink bytes delivered");
    chk(ex_addr.size(), 0, "R5 all read beats issued");
    wr(A_CMD, 32'h00);

    // R6 length caps
    ext_count_en = 1'b0;
    launch(1'b1, 32'h30000, 32'h0);
    rd(A_WCNT, v); chk(v, 32'h10000, "R6 16-bit cap");
    wr(A_CMD, 32'h02);
    rd(A_STAT, v); chk(v, 32'h04, "R9 abort status");
    chk({31'h0, irq_pend}, 32'h1, "R9 irq on abort");
    wr(A_CMD, 32'h00);
    ext_count_en = 1'b1;
    launch(1'b1, 32'h200_0000, 32'h10);
    rd(A_WCNT, v); chk(v, 32'hFF_FFF0, "R6 24-bit cap with boundary");
    wr(A_CMD, 32'h02);
    wr(A_CMD, 32'h00);
    ext_count_en = 1'b0;

    // R7 boundary cut
    plan_beats(32'h00FF_FFF9, 7, 1'b1, 8'h40);
    launch(1'b1, 32'd100, 32'h00FF_FFF9);
    wait_irq(200);
    rd(A_STAT, v); chk(v, 32'h08, "R7 done at boundary");
    rd(A_WADR, v); chk(v, 32'h0100_0000, "R7 stops at 2^24");
    chk(ex_addr.size(), 0, "R7 beats issued");
    wr(A_CMD, 32'h00);

    // R9 memory error
    ex_addr.push_back(32'h300); ex_be.push_back(4'hF); ex_we.push_back(1'b1);
    ex_data.push_back(32'h53525150);
    for (int i = 0; i < 8; i++) src_q.push_back(8'h50 + 8'(i));
    err_arm = 1'b1;
    launch(1'b1, 32'd8, 32'h300);
    wait_irq(200);
    rd(A_STAT, v); chk(v, 32'h02, "R9 error status");
    wait_cycles(10);
    chk({31'h0, mem_req}, 32'h0, "R9 no request after error");
    wr(A_CMD, 32'h02);
    rd(A_STAT, v); chk(v, 32'h06, "R9 error plus abort");
    wr(A_CMD, 32'h00);
    rd(A_STAT, v); chk(v, 32'h00, "R9 idle clears error");
    src_q.delete();
    src_hs = 1'b0;

    // R10 forwarded core interrupt
    @(negedge clk); core_int = 1'b1;
    rd(A_STAT, v); chk(v, 32'h10, "R10 core bit");
    chk({31'h0, irq_pend}, 32'h1, "R10 irq from core");
    @(negedge clk); core_int = 1'b0;
    #1 chk({31'h0, irq_pend}, 32'h0, "R10 irq follows core");

    // R11 flush: 4-byte write to 0x400, then flush 3 bytes at 0x404
    plan_beats(32'h400, 4, 1'b1, 8'h70);
    launch(1'b1, 32'd4, 32'h400);
    wait_irq(200);
    wr(A_CMD, 32'h80);
    ex_addr.push_back(32'h404); ex_be.push_back(4'b0111); ex_we.push_back(1'b1);
    ex_data.push_back(32'h00A3A2A1);
    src_q.push_back(8'hA1); src_q.push_back(8'hA2); src_q.push_back(8'hA3);
    wait_cycles(2);
    wr(A_CMD, 32'h81);
    for (int i = 0; i < 100; i++) begin
      rd(A_STAT, v);
      if (v[5]) break;
    end
    chk(v, 32'h20, "R11 flush complete status");
    chk({31'h0, irq_pend}, 32'h0, "R11 flush raises no irq");
    rd(A_WADR, v); chk(v, 32'h407, "R11 address after flush");
    rd(A_WCNT, v); chk(v, 32'h0, "R11 count untouched");
    chk(ex_addr.size(), 0, "R11 flush beat issued");
    wr(A_CMD, 32'h00);

    wait_cycles(4);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule